// File: doc/BRIEF.md
# Dual-Port Serial Management Target

This block is the management-bus target for a PHY with two ports. A station manager clocks frames over the MDC line and the shared bidirectional MDIO line. The block samples both lines with its own system clock, finds the synchronising run of ones, decodes clause-22 style read and write frames, and serves 16-bit registers held in a separate bank for each port.

A four-bit strap sets the upper bits of the PHY address. The lowest address bit chooses the port, so the two ports answer two adjacent addresses. A write pulses a one-cycle strobe that carries the port, the register number and the data toward the register logic. The same write also updates the block's own copy of the implemented registers. A read returns that stored word on MDIO using tri-state drive. An active-high disable input shuts the interface off completely.

Top module: `mdio_dual_slave`

## Requirements
- R1: A frame is accepted only if at least 32 consecutive 1 bits were sampled before its start field. With only 31 ones, a write gives no strobe and a read never drives MDIO.
- R2: The start field must be 0 then 1. The opcode must be 1,0 (read) or 0,1 (write). Any other start or opcode value makes the frame ignored: no strobe and no drive.
- R3: The frame is ignored unless bits 4..1 of the PHY address equal `strap_addr[3:0]`. An ignored frame gives no strobe and leaves MDIO undriven.
- R4: PHY address bit 0 selects the port: 0 selects bank 0 and 1 selects bank 1. A write to one port leaves the same register of the other port unchanged.
- R5: On a write, the two turnaround bits are followed by 16 data bits, MSB first. After the last data bit is sampled, `wr_stb` pulses high for exactly one clock. During that pulse, `wr_port`, `wr_reg` and `wr_data` hold the frame's port, register number and data.
- R6: On a read, the block does not drive MDIO in the first turnaround bit. It drives 0 in the second bit and then the register word, D15 first. It releases MDIO in the bit that follows D0. Drive changes only after a falling MDC edge, which requires each MDC phase to last at least 3 system clocks.
- R7: Registers 0 to 10 and 15 of each port store written data and read back zero after reset. Every other register reads as zero and ignores writes, although the write still pulses `wr_stb`.
- R8: While `mgmt_off` is high, the block never drives MDIO and never pulses `wr_stb`. Once the input is low again, frames work normally.
- R9: After a frame ends, a new preamble is required. A frame that follows with no run of ones is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_off | input | 1 | High disables the whole interface |
| strap_addr | input | 4 | Upper PHY address bits 4..1 |
| mdc | input | 1 | Management clock |
| mdio_i | input | 1 | Level sensed on the MDIO line |
| mdio_o | output | 1 | Value to drive on MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_port | output | 1 | Port of the write |
| wr_reg | output | 5 | Register number of the write |
| wr_data | output | 16 | Data of the write |

## Verification
A wrong preamble count, or a header bit taken at the wrong position, shows up within one frame. The symptom is either a missing write strobe or a drive on MDIO for a frame that should have been ignored. A miscounted turnaround or data phase shifts the read word by one bit, and the second turnaround bit is no longer seen as a driven 0. Both show in the same read frame. A bank index error only shows up on a later read of the other port, so writes to the two ports are each followed by reads of both ports.

// File: rtl/mdio_dual_slave.sv
module mdio_dual_slave #(
  parameter int PRE_LEN = 32,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mgmt_off,
  input  logic [3:0]    strap_addr,
  input  logic          mdc,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          wr_stb,
  output logic          wr_port,
  output logic [4:0]    wr_reg,
  output logic [DW-1:0] wr_data
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam int CW = $clog2(DW + 4);
  localparam logic [PW-1:0] PRE_FULL = PW'(PRE_LEN);
  localparam logic [CW-1:0] HDR_LAST = CW'(12);
  localparam logic [CW-1:0] TA_END   = CW'(1);
  localparam logic [CW-1:0] D_LAST   = CW'(DW + 1);
  localparam logic [CW-1:0] REL      = CW'(DW + 2);

  typedef enum logic [1:0] {S_WAIT, S_HDR, S_RD, S_WR} st_t;

  st_t            st;
  logic [PW-1:0]  pre;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  sh, rsh;
  logic [DW-1:0]  bank [2][16];
  logic           mdc_s1, mdc_s2, mdio_s1;
  logic           port_q, oe_r, o_r;
  logic [4:0]     reg_q;

  wire rise = mdc_s1 & ~mdc_s2;
  wire fall = ~mdc_s1 & mdc_s2;

  wire [12:0] hdr    = {sh[11:0], mdio_s1};
  wire        h_port = hdr[5];
  wire [4:0]  h_reg  = hdr[4:0];
  wire        h_ok   = hdr[12] && (hdr[9:6] == strap_addr);
  wire        h_rd   = h_ok && (hdr[11:10] == 2'b10);
  wire        h_wr   = h_ok && (hdr[11:10] == 2'b01);

  function automatic logic impl(input logic [4:0] r);
    return (r <= 5'd10) || (r == 5'd15);
  endfunction

  wire [DW-1:0] rd_val = impl(h_reg) ? bank[h_port][h_reg[3:0]] : '0;

  assign mdio_o  = o_r;
  assign mdio_oe = oe_r;
  assign wr_port = port_q;
  assign wr_reg  = reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_s1 <= 1'b0; mdc_s2 <= 1'b0; mdio_s1 <= 1'b1;
      st <= S_WAIT; pre <= '0; cnt <= '0; sh <= '0; rsh <= '0;
      port_q <= 1'b0; reg_q <= '0; oe_r <= 1'b0; o_r <= 1'b0;
      wr_stb <= 1'b0; wr_data <= '0;
      for (int p = 0; p < 2; p++)
        for (int r = 0; r < 16; r++) bank[p][r] <= '0;
    end else begin
      mdc_s1  <= mdc;
      mdc_s2  <= mdc_s1;
      mdio_s1 <= mdio_i;
      wr_stb  <= 1'b0;
      if (mgmt_off) begin
        st <= S_WAIT; pre <= '0; oe_r <= 1'b0;
      end else begin
        case (st)
          S_WAIT: if (rise) begin
            if (mdio_s1) pre <= (pre == PRE_FULL) ? pre : pre + 1'b1;
            else if (pre == PRE_FULL) begin st <= S_HDR; cnt <= '0; pre <= '0; end
            else pre <= '0;
          end
          S_HDR: if (rise) begin
            sh  <= {sh[DW-2:0], mdio_s1};
            cnt <= cnt + 1'b1;
            if (cnt == HDR_LAST) begin
              cnt    <= '0;
              port_q <= h_port;
              reg_q  <= h_reg;
              rsh    <= rd_val;
              if (h_rd)      st <= S_RD;
              else if (h_wr) st <= S_WR;
              else           st <= S_WAIT;
            end
          end
          S_RD: if (fall) begin
            cnt <= cnt + 1'b1;
            if (cnt == TA_END) begin
              oe_r <= 1'b1; o_r <= 1'b0;
            end else if (cnt > TA_END && cnt <= D_LAST) begin
              o_r <= rsh[DW-1];
              rsh <= {rsh[DW-2:0], 1'b0};
            end else if (cnt == REL) begin
              oe_r <= 1'b0; st <= S_WAIT;
            end
          end
          S_WR: if (rise) begin
            cnt <= cnt + 1'b1;
            sh  <= {sh[DW-2:0], mdio_s1};
            if (cnt == D_LAST) begin
              wr_stb  <= 1'b1;
              wr_data <= {sh[DW-2:0], mdio_s1};
              st      <= S_WAIT;
              if (impl(reg_q)) bank[port_q][reg_q[3:0]] <= {sh[DW-2:0], mdio_s1};
            end
          end
          default: st <= S_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_dual_slave_chk.sv
module mdio_dual_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic mgmt_off,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic wr_stb
);
  p_off_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_off |=> !mdio_oe);
  p_off_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_off |=> !wr_stb);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_first_drive_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  p_drive_change_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mdio_oe != $past(mdio_oe)) && !$past(mgmt_off)) |-> !mdc);
endmodule

bind mdio_dual_slave mdio_dual_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mgmt_off(mgmt_off), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .wr_stb(wr_stb)
);

// File: tb/mdio_dual_slave_tb_top.sv
module mdio_dual_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, off = 1'b0;
  logic c_oe = 1'b0, c_val = 1'b1;
  logic [3:0] strap = 4'b1010;
  logic d_o, d_oe, stb, w_port;
  logic [4:0] w_reg;
  logic [15:0] w_data;
  wire line = d_oe ? d_o : (c_oe ? c_val : 1'b1);

  always #10 clk = ~clk;

  mdio_dual_slave dut_i (
    .clk(clk), .rst_n(rst_n), .mgmt_off(off), .strap_addr(strap),
    .mdc(mdc), .mdio_i(line), .mdio_o(d_o), .mdio_oe(d_oe),
    .wr_stb(stb), .wr_port(w_port), .wr_reg(w_reg), .wr_data(w_data)
  );

  typedef struct packed { logic p; logic [4:0] r; logic [15:0] d; } wr_t;
  wr_t         exp_wr[$];
  logic [15:0] exp_rd[$];
  logic [15:0] model [2][32];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "";
  wr_t mon_e;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && stb) begin
    if (exp_wr.size() == 0) chk(0, {cur_tag, " unexpected strobe"}, {w_port, w_reg, w_data}, 0);
    else begin
      mon_e = exp_wr.pop_front();
      chk({w_port, w_reg, w_data} == mon_e, {cur_tag, " R5 strobe fields"}, {w_port, w_reg, w_data}, mon_e);
    end
  end

  function automatic bit impl(input logic [4:0] r);
    return (r <= 5'd10) || (r == 5'd15);
  endfunction

  task automatic send_bit(input bit drv, input bit b, output logic sl, output logic se, output logic so);
    mdc = 0; c_oe = drv; c_val = b;
    repeat (4) @(negedge clk);
    sl = line; se = d_oe; so = d_o;
    mdc = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input int pre_n, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                       input bit act, input string tag);
    logic l, e, o;
    logic [15:0] got = '0, ex;
    logic [13:0] hdr = {st, op, phy, rg};
    bit anyoe = 0;
    cur_tag = tag;
    send_bit(1, 0, l, e, o);
    for (int i = 0; i < pre_n; i++) send_bit(1, 1, l, e, o);
    for (int i = 13; i >= 0; i--) send_bit(1, hdr[i], l, e, o);
    if (op == 2'b10) begin
      if (act) exp_rd.push_back(model[phy[0]][rg]);
      send_bit(0, 1, l, e, o);
      anyoe |= e;
      if (act) chk(!e, {tag, " R6 first turnaround undriven"}, e, 0);
      send_bit(0, 1, l, e, o);
      anyoe |= e;
      if (act) chk(e && !o, {tag, " R6 second turnaround drives 0"}, {e, o}, 2'b10);
      for (int i = 0; i < 16; i++) begin
        send_bit(0, 1, l, e, o);
        anyoe |= e;
        got = {got[14:0], l};
      end
      if (act) begin
        ex = exp_rd.pop_front();
        chk(got == ex, {tag, " read data"}, got, ex);
        send_bit(0, 1, l, e, o);
        chk(!e, {tag, " R6 release after D0"}, e, 0);
      end else chk(!anyoe, {tag, " ignored read must not drive"}, anyoe, 0);
    end else begin
      if (act) begin
        exp_wr.push_back({phy[0], rg, wd});
        if (impl(rg)) model[phy[0]][rg] = wd;
      end
      send_bit(1, 1, l, e, o);
      send_bit(1, 0, l, e, o);
      for (int i = 15; i >= 0; i--) send_bit(1, wd[i], l, e, o);
      c_oe = 0;
      repeat (6) @(negedge clk);
      chk(exp_wr.size() == 0, {tag, " R5 strobe issued"}, exp_wr.size(), 0);
    end
    c_oe = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  localparam logic [4:0] P0 = 5'b10100, P1 = 5'b10101;

  initial begin
    for (int p = 0; p < 2; p++) for (int r = 0; r < 32; r++) model[p][r] = '0;
    repeat (5) @(negedge clk);
    chk(!d_oe && !stb, "reset outputs idle R8", {d_oe, stb}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    frame(32, 2'b01, 2'b10, P0, 5'd7, 0, 1, "R7 reset value");
    frame(32, 2'b01, 2'b01, P0, 5'd3, 16'hA5C3, 1, "R5 write p0");
    frame(32, 2'b01, 2'b10, P0, 5'd3, 0, 1, "R6 read p0");
    frame(32, 2'b01, 2'b01, P1, 5'd3, 16'h1234, 1, "R4 write p1");
    frame(32, 2'b01, 2'b10, P1, 5'd3, 0, 1, "R4 read p1");
    frame(32, 2'b01, 2'b10, P0, 5'd3, 0, 1, "R4 p0 unchanged");
    frame(32, 2'b01, 2'b01, P1, 5'd15, 16'hFFFF, 1, "R7 write r15");
    frame(32, 2'b01, 2'b10, P1, 5'd15, 0, 1, "R7 read r15");
    frame(32, 2'b01, 2'b01, P0, 5'd20, 16'hBEEF, 1, "R7 write unimpl");
    frame(32, 2'b01, 2'b10, P0, 5'd20, 0, 1, "R7 unimpl reads 0");
    frame(32, 2'b01, 2'b10, P1, 5'd11, 0, 1, "R7 r11 reads 0");
    frame(32, 2'b01, 2'b01, P0, 5'd10, 16'h0F0F, 1, "R7 write r10");
    frame(32, 2'b01, 2'b10, P0, 5'd10, 0, 1, "R7 read r10");
    frame(32, 2'b01, 2'b01, 5'b00100, 5'd3, 16'hDEAD, 0, "R3 wrong strap write");
    frame(32, 2'b01, 2'b10, 5'b00100, 5'd3, 0, 0, "R3 wrong strap read");
    frame(31, 2'b01, 2'b01, P0, 5'd3, 16'h1111, 0, "R1 short preamble write");
    frame(31, 2'b01, 2'b10, P0, 5'd3, 0, 0, "R1 short preamble read");
    frame(32, 2'b01, 2'b11, P0, 5'd3, 16'h3333, 0, "R2 opcode 11");
    frame(32, 2'b01, 2'b00, P0, 5'd3, 16'h4444, 0, "R2 opcode 00");
    frame(32, 2'b00, 2'b01, P0, 5'd3, 16'h5555, 0, "R2 start 00");
    frame(32, 2'b00, 2'b10, P0, 5'd3, 0, 0, "R2 start 00 read");
    frame(32, 2'b01, 2'b10, P0, 5'd3, 0, 1, "R1 R2 R3 value kept");
    off = 1;
    frame(32, 2'b01, 2'b01, P0, 5'd3, 16'h2222, 0, "R8 disabled write");
    frame(32, 2'b01, 2'b10, P0, 5'd3, 0, 0, "R8 disabled read");
    off = 0;
    frame(32, 2'b01, 2'b10, P0, 5'd3, 0, 1, "R8 re-enabled read");
    frame(32, 2'b01, 2'b01, P0, 5'd4, 16'h4444, 1, "R9 write");
    frame(0, 2'b01, 2'b01, P0, 5'd4, 16'h5555, 0, "R9 no preamble");
    frame(32, 2'b01, 2'b10, P0, 5'd4, 0, 1, "R9 value kept");
    done = 1;
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      finish_up();
    end
  end
endmodule